// File: doc/BRIEF.md
# Four-Flag Accumulator ALU

This is the combinational 8-bit arithmetic and logic unit for a small CPU whose flag byte carries only four flags: zero, subtract, half-carry and carry. In the same evaluation it takes the accumulator, a second operand, a 3-bit operation code, the current flag byte and a one-bit select for the single-operand group. It returns a result byte, a write-back enable and the next flag byte. Register files, operand fetch and decimal adjustment belong to the surrounding core.

When the select is low, the 3-bit code picks one of eight two-operand operations. The code is taken straight from bits 5..3 of the instruction byte. When the select is high, the same 3 bits pick one of the single-operand operations: increment, decrement, complement, set carry or complement carry. The core writes the result back only when the enable is high. Whenever the enable is low, the result port carries the accumulator unchanged.

Top module: `alu4_core`

## Requirements
- R1: The output flag byte is laid out zero=bit7, subtract=bit6, half=bit5, carry=bit4, and bits 3..0 are always 0 whatever the input flag byte holds. The input flag byte uses the same layout.
- R2: With the select low, code 0 (add) and code 1 (add with carry) write acc+opnd (+carry-in for code 1 only). Zero is set when the 8-bit result is 0. Half is the carry out of bit 3, carry is the carry out of bit 7, and subtract is cleared.
- R3: Code 2 (subtract) and code 3 (subtract with borrow) write acc-opnd (-carry-in for code 3 only). Subtract is set. Half is the borrow into bit 4, carry is the borrow out of bit 7, and zero is set when the difference is 0.
- R4: Code 7 (compare) produces the flags of code 2 but deasserts the write enable, and the result port equals the accumulator.
- R5: Code 4 (and) writes acc&opnd, sets zero from the result, sets half and clears subtract and carry.
- R6: Code 5 (xor) and code 6 (or) write acc^opnd and acc|opnd. Zero comes from the result and subtract, half and carry are cleared.
- R7: With the select high, code 0 writes opnd+1 and code 1 writes opnd-1. Zero comes from the result. Half is set on a carry out of bit 3 for the increment and on a borrow into bit 4 for the decrement. Subtract is 0 for the increment and 1 for the decrement, and carry keeps its input value.
- R8: Select high with code 2 writes ~acc, sets subtract and half, and keeps zero and carry.
- R9: Select high with code 3 sets carry. Code 4 inverts carry. Both clear subtract and half, keep zero, deassert the write enable and pass the accumulator to the result port.
- R10: Select high with codes 5, 6 or 7 deasserts the write enable, passes the accumulator and returns the input flags with bits 3..0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; the source of increment and decrement |
| op_i | input | 3 | Operation code (instruction bits 5..3, or single-operand code) |
| unary_i | input | 1 | High selects the single-operand group |
| flags_i | input | 8 | Current flag byte |
| res_o | output | 8 | Result byte |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 8 | Next flag byte |

## Verification
The checks assume every input carries a defined 0/1 value once evaluation settles. They also assume the low nibble of the incoming flag byte may hold anything, so it is never trusted. The bench keeps every input at a known level from time zero. It deliberately fills the incoming low nibble and the unused flag bits with changing junk, so the rules that ignore or preserve those bits are exercised. Operands sweep the full accumulator range against a set of nibble- and sign-boundary values, with both carry-in values.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int DW   = 8;
  localparam int NW   = DW / 2;
  localparam int FZ   = 7;
  localparam int FN   = 6;
  localparam int FH   = 5;
  localparam int FC   = 4;
  localparam int OPW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBC = 3'd3,
    OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CP  = 3'd7
  } alu_op_e;

  typedef enum logic [OPW-1:0] {
    UN_INC = 3'd0, UN_DEC = 3'd1, UN_CPL = 3'd2, UN_SCF = 3'd3, UN_CCF = 3'd4
  } un_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

  function automatic logic [DW-1:0] pack_flags(input flag_t f);
    return {f, {(DW-4){1'b0}}};
  endfunction

  function automatic flag_t unpack_flags(input logic [DW-1:0] fb);
    flag_t f;
    f.z = fb[FZ];
    f.n = fb[FN];
    f.h = fb[FH];
    f.c = fb[FC];
    return f;
  endfunction

  // Adds x + y + ci over w bits, returning {carry, sum}.
  function automatic logic [DW:0] wide_add(input logic [DW-1:0] x,
                                           input logic [DW-1:0] y,
                                           input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  endfunction

  // Carry out of the low nibble for x + y + ci.
  function automatic logic nib_carry(input logic [NW-1:0] x,
                                     input logic [NW-1:0] y,
                                     input logic ci);
    logic [NW:0] t;
    t = {1'b0, x} + {1'b0, y} + {{NW{1'b0}}, ci};
    return t[NW];
  endfunction
endpackage

// File: rtl/alu4_arith.sv
module alu4_arith
  import alu4_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          hc_o
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   full;
  logic          nib;

  // Subtraction: a + ~b + ~borrow_in, with carries inverted into borrows.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign full  = wide_add(a_i, b_eff, c_eff);
  assign nib   = nib_carry(a_i[NW-1:0], b_eff[NW-1:0], c_eff);
  assign sum_o = full[DW-1:0];
  assign cy_o  = sub_i ? ~full[DW] : full[DW];
  assign hc_o  = sub_i ? ~nib : nib;
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
  import alu4_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/alu4_unary.sv
module alu4_unary
  import alu4_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [OPW-1:0] code_i,
  input  flag_t          f_i,
  output logic [DW-1:0]  res_o,
  output logic           we_o,
  output flag_t          f_o
);
  logic [DW:0] inc_w;
  logic [DW:0] dec_w;

  assign inc_w = wide_add(b_i, {DW{1'b0}}, 1'b1);
  assign dec_w = wide_add(b_i, {DW{1'b1}}, 1'b0);

  always_comb begin
    res_o = a_i;
    we_o  = 1'b0;
    f_o   = f_i;
    case (code_i)
      UN_INC: begin
        res_o = inc_w[DW-1:0];
        we_o  = 1'b1;
        f_o.z = (inc_w[DW-1:0] == '0);
        f_o.n = 1'b0;
        f_o.h = (b_i[NW-1:0] == {NW{1'b1}});
      end
      UN_DEC: begin
        res_o = dec_w[DW-1:0];
        we_o  = 1'b1;
        f_o.z = (dec_w[DW-1:0] == '0);
        f_o.n = 1'b1;
        f_o.h = (b_i[NW-1:0] == {NW{1'b0}});
      end
      UN_CPL: begin
        res_o = ~a_i;
        we_o  = 1'b1;
        f_o.n = 1'b1;
        f_o.h = 1'b1;
      end
      UN_SCF: begin
        f_o.n = 1'b0;
        f_o.h = 1'b0;
        f_o.c = 1'b1;
      end
      UN_CCF: begin
        f_o.n = 1'b0;
        f_o.h = 1'b0;
        f_o.c = ~f_i.c;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [2:0] op_i,
  input  logic       unary_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic       wr_o,
  output logic [7:0] flags_o
);
  alu_op_e       op;
  flag_t         f_in;
  flag_t         f_bin;
  flag_t         f_un;
  logic          is_sub;
  logic          uses_cin;
  logic          arith_cin;
  logic [DW-1:0] arith_sum;
  logic          arith_cy;
  logic          arith_hc;
  logic [DW-1:0] logic_res;
  logic [DW-1:0] un_res;
  logic          un_we;
  logic [DW-1:0] bin_res;
  logic          bin_we;
  logic          unused_low;

  assign op         = alu_op_e'(op_i);
  assign f_in       = unpack_flags(flags_i);
  assign unused_low = ^flags_i[3:0];
  assign is_sub     = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
  assign uses_cin   = (op == OP_ADC) || (op == OP_SBC);
  assign arith_cin  = uses_cin & f_in.c;

  alu4_arith u_arith (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (arith_cin),
    .sub_i (is_sub),
    .sum_o (arith_sum),
    .cy_o  (arith_cy),
    .hc_o  (arith_hc)
  );

  alu4_logic u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_i[1:0] - 2'd0),
    .res_o (logic_res)
  );

  alu4_unary u_unary (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .code_i (op_i),
    .f_i    (f_in),
    .res_o  (un_res),
    .we_o   (un_we),
    .f_o    (f_un)
  );

  always_comb begin
    bin_res = arith_sum;
    bin_we  = 1'b1;
    f_bin   = '{z: (arith_sum == '0), n: is_sub, h: arith_hc, c: arith_cy};
    case (op)
      OP_CP: begin
        bin_res = acc_i;
        bin_we  = 1'b0;
      end
      OP_AND: begin
        bin_res = logic_res;
        f_bin   = '{z: (logic_res == '0), n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_XOR, OP_OR: begin
        bin_res = logic_res;
        f_bin   = '{z: (logic_res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      default: ;
    endcase
  end

  assign res_o   = unary_i ? un_res : bin_res;
  assign wr_o    = unary_i ? un_we  : bin_we;
  assign flags_o = pack_flags(unary_i ? f_un : f_bin);
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk (
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [2:0] op_i,
  input logic       unary_i,
  input logic [7:0] flags_i,
  input logic [7:0] res_o,
  input logic       wr_o,
  input logic [7:0] flags_o,
  input logic       is_sub,
  input logic       arith_cy
);
  logic [8:0] plain_sum;
  assign plain_sum = {1'b0, acc_i} + {1'b0, opnd_i};

  always_comb begin
    // R1
    low_nibble_zero_chk: assert (flags_o[3:0] == 4'h0);
    // R2
    add_carry_chk: assert (unary_i || op_i != 3'd0 ||
                           (flags_o[4] == plain_sum[8] && !flags_o[6] &&
                            flags_o[7] == (res_o == 8'h00)));
    // R3
    sub_flag_chk: assert (unary_i || !is_sub ||
                          (flags_o[6] && flags_o[4] == arith_cy));
    // R4
    cmp_nowrite_chk: assert (unary_i || op_i != 3'd7 || (!wr_o && res_o == acc_i));
    // R5
    and_flags_chk: assert (unary_i || op_i != 3'd4 ||
                           (flags_o[6:4] == 3'b010 && res_o == (acc_i & opnd_i)));
    // R7
    incdec_keep_c_chk: assert (!unary_i || op_i > 3'd1 ||
                               (flags_o[4] == flags_i[4] && flags_o[6] == op_i[0]));
    // R9
    scf_set_chk: assert (!unary_i || op_i != 3'd3 ||
                         (flags_o[6:4] == 3'b001 && !wr_o && flags_o[7] == flags_i[7]));
    // R10
    reserved_chk: assert (!unary_i || op_i < 3'd5 ||
                          (!wr_o && flags_o == {flags_i[7:4], 4'h0} && res_o == acc_i));
  end
endmodule

bind alu4_core alu4_chk u_chk (
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .op_i     (op_i),
  .unary_i  (unary_i),
  .flags_i  (flags_i),
  .res_o    (res_o),
  .wr_o     (wr_o),
  .flags_o  (flags_o),
  .is_sub   (is_sub),
  .arith_cy (arith_cy)
);

// File: tb/alu4_core_bench.sv
`timescale 1ns/1ps
module alu4_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [2:0] op_i = 3'd0;
  logic       unary_i = 1'b0;
  logic [7:0] flags_i = 8'h00;
  logic [7:0] res_o;
  logic       wr_o;
  logic [7:0] flags_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu4_core u_alu4_core (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .op_i    (op_i),
    .unary_i (unary_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .wr_o    (wr_o),
    .flags_o (flags_o)
  );

  function automatic string req_name(input bit un, input int code);
    if (un) begin
      case (code)
        0, 1:    return "R7";
        2:       return "R8";
        3, 4:    return "R9";
        default: return "R10";
      endcase
    end
    case (code)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4:       return "R5";
      5, 6:    return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input string req, input int er, input int ew, input int ef);
    n_run++;
    if (res_o !== 8'(er) || wr_o !== 1'(ew) || flags_o !== 8'(ef)) begin
      n_fail++;
      $display("FAIL %s: acc=%02h opnd=%02h op=%0d un=%0d fin=%02h got res=%02h wr=%0d fl=%02h exp res=%02h wr=%0d fl=%02h",
               req, acc_i, opnd_i, op_i, unary_i, flags_i, res_o, wr_o, flags_o,
               er, ew, ef);
    end
  endtask

  // Expected values for the two-operand group, worked out as integers.
  task automatic expect_bin(input int a, input int b, input int code, input int fin,
                            output int er, output int ew, output int ef);
    int ci, d, z, n, h, c, r;
    ci = ((code == 1 || code == 3) && ((fin >> 4) & 1)) ? 1 : 0;
    ew = 1; n = 0; h = 0; c = 0;
    case (code)
      0, 1: begin
        d = a + b + ci;
        r = d % 256;
        c = (d > 255) ? 1 : 0;
        h = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
      end
      2, 3, 7: begin
        d = a - b - ci;
        r = (d + 256) % 256;
        c = (d < 0) ? 1 : 0;
        h = ((a % 16) - (b % 16) - ci < 0) ? 1 : 0;
        n = 1;
      end
      4: begin r = a & b; h = 1; end
      5: r = a ^ b;
      default: r = a | b;
    endcase
    z = (r == 0) ? 1 : 0;
    ef = z * 128 + n * 64 + h * 32 + c * 16;
    er = r;
    if (code == 7) begin er = a; ew = 0; end
  endtask

  task automatic expect_un(input int a, input int b, input int code, input int fin,
                           output int er, output int ew, output int ef);
    int z, n, h, c;
    z = (fin >> 7) & 1; n = (fin >> 6) & 1; h = (fin >> 5) & 1; c = (fin >> 4) & 1;
    er = a; ew = 0;
    case (code)
      0: begin er = (b + 1) % 256; ew = 1; z = (er == 0); n = 0; h = ((b % 16) == 15); end
      1: begin er = (b + 255) % 256; ew = 1; z = (er == 0); n = 1; h = ((b % 16) == 0); end
      2: begin er = 255 - a; ew = 1; n = 1; h = 1; end
      3: begin n = 0; h = 0; c = 1; end
      4: begin n = 0; h = 0; c = 1 - c; end
      default: ;
    endcase
    ef = z * 128 + n * 64 + h * 32 + c * 16;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int er, ew, ef;
    logic [7:0] bl [16];
    bl = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h11, 8'h3C, 8'h7F,
           8'h80, 8'h81, 8'hA5, 8'hC3, 8'hEF, 8'hF0, 8'hFE, 8'hFF};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give 0 + 0 with zero set (R1, R2).
    @(negedge clk);
    #1 compare("R1 idle", 0, 1, 8'h80);

    // R1..R6: two-operand group, all accumulators against boundary operands.
    for (int code = 0; code < 8; code++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int cf = 0; cf < 2; cf++) begin
            @(negedge clk);
            acc_i   = 8'(a);
            opnd_i  = bl[bi];
            op_i    = 3'(code);
            unary_i = 1'b0;
            flags_i = {a[0] ? 1'b1 : 1'b0, a[1] ? 1'b1 : 1'b0, bl[bi][0], 1'(cf),
                       4'(a >> 4) ^ bl[bi][3:0]};
            expect_bin(a, int'(bl[bi]), code, int'(flags_i), er, ew, ef);
            #1 compare(req_name(1'b0, code), er, ew, ef);
          end
        end
      end
    end

    // R7..R10 and R1: single-operand group over every value and flag combination.
    for (int code = 0; code < 8; code++) begin
      for (int x = 0; x < 256; x++) begin
        for (int fl = 0; fl < 16; fl++) begin
          @(negedge clk);
          acc_i   = 8'(x);
          opnd_i  = 8'(x) ^ 8'h5A;
          op_i    = 3'(code);
          unary_i = 1'b1;
          flags_i = {4'(fl), 4'(x)};
          expect_un(x, int'(opnd_i), code, int'(flags_i), er, ew, ef);
          #1 compare(req_name(1'b1, code), er, ew, ef);
        end
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule